// File: doc/BRIEF.md
# Stack Write-Acknowledge Sequencer

This block is a host-side SPI master that sets up a daisy-chained stack of serial monitoring devices and then confirms that each device in the stack took the write. It runs a fixed sequence of frames. The first two frames are broadcast writes that every device accepts. The first one points each device's readback selector at a chosen register. The second one writes a control high byte that the caller supplies. After these two frames the block clocks one readback frame per device. The frames return in chain order, starting with the device nearest the host.

Every outgoing command carries an 8-bit CRC, which the block generates serially while the header bits shift out. Every returned frame carries its own 8-bit CRC, which the block checks as the frame arrives. When the last frame ends, the block pulses `done`. It also presents two vectors with one bit per device: one for acknowledged writes and one for CRC failures. These vectors stay valid until the next `start`. The SCLK rate comes from the system clock through a divider that is latched at `start`. This lets a slow rate be chosen when the stack needs one.

Top module: `stack_ack_sequencer`

## Requirements
- R1: While reset is held and after it is released, `cs_n` and `sclk` are high, `busy` and `done` are low, and both result vectors are zero.
- R2: Every command is 32 bits, sent MSB first. The fields are: bits 31:27 device address, bits 26:21 register address, bits 20:13 data, bit 12 broadcast flag, bit 11 zero, bits 10:3 CRC, bits 2:0 the pattern 3'b010. The CRC is the remainder of bits 31:11, taken as a 21-bit polynomial, divided by x^8+x^5+x^3+x^2+x+1. No zeros are appended before the division.
- R3: Frame 0 is a broadcast write (device address 0, flag 1) of data 0x0E to register 0x1C. Frame 1 is a broadcast write (device address 0, flag 1) of `ctrl_hi` to register 0x0D. `ctrl_hi` is latched at `start`.
- R4: After frame 1, exactly N_DEV readback frames follow, each with the command word 0xF800030A. The sequence then stops, for N_DEV+2 frames in total.
- R5: SCLK idles high. MOSI changes only on a falling SCLK edge. MISO is sampled on a rising edge. Each frame has exactly 32 rising edges inside one low period of `cs_n`.
- R6: Each SCLK phase lasts `sclk_div`+1 system clocks, so one full SCLK period is 2·(`sclk_div`+1) clocks. The divider value is latched at `start`, and later changes to it have no effect on the running sequence.
- R7: Readback frame k (k = 0 for the device nearest the host) sets bit k of `ack_vec` to bit 10 of the returned word. This happens only when that word's CRC is correct.
- R8: A returned word carries its CRC in bits 9:2. That CRC covers bits 31:10 with the same polynomial as R2. On a mismatch, bit k of `crc_err_vec` is set and bit k of `ack_vec` is cleared, whatever bit 10 holds.
- R9: `busy` is high from the cycle after `start` until `done`. `done` is a single-cycle pulse after the last frame ends. `start` clears both vectors, and they then hold their values until the next `start`.
- R10: A `start` pulse while `busy` is high is ignored, including any new `ctrl_hi` and `sclk_div` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the sequence when idle |
| ctrl_hi | input | 8 | Control high byte for the broadcast write |
| sclk_div | input | DIV_W | SCLK phase length minus one, in system clocks |
| miso | input | 1 | Serial data from the stack |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data to the stack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_vec | output | N_DEV | Per-device acknowledge, CRC-qualified |
| crc_err_vec | output | N_DEV | Per-device returned-CRC failure |

## Verification
The bench drives the sequence with a model of the stack. The stack returns a chosen acknowledge mask and a chosen corrupted-CRC mask for each run. The cases are: all devices acknowledging, none acknowledging, a sparse pattern, and corruption at the two ends of the chain. Together these separate the acknowledge path from the CRC path and show that frame order matches device order. Control bytes and divider settings change from run to run. This exercises both the serially generated write CRC and the SCLK timing. It also shows whether the readback word matches its known constant. A second `start` with different settings, sent partway through a run, shows whether the running sequence ignores it.

// File: rtl/ackseq_pkg.sv
package ackseq_pkg;

    localparam int FRAME_W = 32;
    localparam int HDR_W   = 21;   // bits 31:11 covered by the write CRC
    localparam int CRC_W   = 8;
    localparam int RDB_W   = 22;   // bits 31:10 covered by the readback CRC
    localparam int RX_CRC_LSB = 2;
    localparam int ACK_POS = 10;

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;   // x^8+x^5+x^3+x^2+x+1
    localparam logic [2:0]       WR_TAIL  = 3'b010;
    localparam logic [4:0]       BCAST_DEV = 5'h00;
    localparam logic [4:0]       POLL_DEV  = 5'h1F;

    typedef enum logic [2:0] {
        E_IDLE, E_SETUP, E_LOW, E_HIGH, E_HOLD, E_GAP
    } eng_st_e;

    typedef enum logic [0:0] {
        S_IDLE, S_RUN
    } seq_st_e;

    function automatic logic [HDR_W-1:0] make_hdr(
        input logic [4:0] dev,
        input logic [5:0] reg_a,
        input logic [7:0] dat,
        input logic       all
    );
        return {dev, reg_a, dat, all, 1'b0};
    endfunction

endpackage

// File: rtl/ackseq_crc8.sv
module ackseq_crc8 #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  POLY = 8'h2F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_d, crc_q;

    // Horner step: r = r*x + din mod P (non-augmented remainder, R2/R8)
    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[W-2:0], din} ^ (crc_q[W-1] ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    a_r2_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && !$past(en)) |-> $stable(crc_q));

endmodule

// File: rtl/ackseq_spi_engine.sv
module ackseq_spi_engine
    import ackseq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [HDR_W-1:0]   hdr,
    input  logic [DIV_W-1:0]   half_div,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic               idle,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               rx_crc_ok
);

    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int CSEL_W  = $clog2(CRC_W);
    localparam int TXC_END = HDR_W + CRC_W;

    typedef struct packed {
        eng_st_e            st;
        logic [DIV_W-1:0]   cnt;
        logic [BIT_W-1:0]   bit_i;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic               sclk;
        logic               cs_n;
        logic               mosi;
        logic               done;
        logic               ok;
    } eng_t;

    eng_t q, d;

    logic [CRC_W-1:0]  txc, rxc;
    logic              txc_clr, txc_en, txc_din;
    logic              rxc_clr, rxc_en;
    logic              expire;
    logic [BIT_W-1:0]  lb;
    logic [CSEL_W-1:0] csel;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        txc_clr = 1'b0;
        txc_en  = 1'b0;
        txc_din = q.tx[FRAME_W-1];
        rxc_clr = 1'b0;
        rxc_en  = 1'b0;
        expire  = (q.cnt == '0);
        lb      = (q.st == E_HIGH) ? q.bit_i + 1'b1 : q.bit_i;
        csel    = CSEL_W'(BIT_W'(TXC_END - 1) - lb);
        if (!expire) d.cnt = q.cnt - 1'b1;

        case (q.st)
            E_IDLE: begin
                if (go) begin
                    d.st    = E_SETUP;
                    d.cs_n  = 1'b0;
                    d.cnt   = half_div;
                    d.tx    = {hdr, {CRC_W{1'b0}}, WR_TAIL};
                    d.bit_i = '0;
                    txc_clr = 1'b1;
                    rxc_clr = 1'b1;
                end
            end
            E_SETUP, E_HIGH: begin
                if (expire) begin
                    if (q.st == E_HIGH && q.bit_i == BIT_W'(FRAME_W - 1)) begin
                        d.st  = E_HOLD;
                        d.cnt = half_div;
                    end else begin
                        // falling edge: launch next bit (R5)
                        d.st    = E_LOW;
                        d.sclk  = 1'b0;
                        d.cnt   = half_div;
                        d.bit_i = lb;
                        d.tx    = q.tx << 1;
                        if (lb < BIT_W'(HDR_W)) begin
                            d.mosi = q.tx[FRAME_W-1];
                            txc_en = 1'b1;
                        end else if (lb < BIT_W'(TXC_END)) begin
                            d.mosi = txc[csel];   // spliced CRC (R2)
                        end else begin
                            d.mosi = q.tx[FRAME_W-1];
                        end
                    end
                end
            end
            E_LOW: begin
                if (expire) begin
                    // rising edge: sample returned bit (R5)
                    d.st   = E_HIGH;
                    d.sclk = 1'b1;
                    d.cnt  = half_div;
                    d.rx   = {q.rx[FRAME_W-2:0], miso};
                    if (q.bit_i < BIT_W'(RDB_W)) rxc_en = 1'b1;
                end
            end
            E_HOLD: begin
                if (expire) begin
                    d.st   = E_GAP;
                    d.cs_n = 1'b1;
                    d.cnt  = half_div;
                    d.ok   = (rxc == q.rx[RX_CRC_LSB +: CRC_W]);   // R8
                end
            end
            E_GAP: begin
                if (expire) begin
                    d.st   = E_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = E_IDLE;
        endcase
    end

    // R1: select and clock idle high out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: E_IDLE, cnt: '0, bit_i: '0, tx: '0, rx: '0,
                   sclk: 1'b1, cs_n: 1'b1, mosi: 1'b0, done: 1'b0, ok: 1'b0};
        end else begin
            q <= d;
        end
    end

    ackseq_crc8 #(.W(CRC_W), .POLY(CRC_POLY)) u_txcrc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (txc_clr),
        .en    (txc_en),
        .din   (txc_din),
        .crc   (txc)
    );

    ackseq_crc8 #(.W(CRC_W), .POLY(CRC_POLY)) u_rxcrc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rxc_clr),
        .en    (rxc_en),
        .din   (miso),
        .crc   (rxc)
    );

    assign sclk       = q.sclk;
    assign cs_n       = q.cs_n;
    assign mosi       = q.mosi;
    assign idle       = (q.st == E_IDLE);
    assign frame_done = q.done;
    assign rx_word    = q.rx;
    assign rx_crc_ok  = q.ok;

    a_r5_sclk_high_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> q.sclk);

    a_r6_sclk_holds_mid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0) |=> (q.sclk == $past(q.sclk)));

    a_r5_mosi_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mosi != $past(q.mosi)) |-> (!q.sclk && $past(q.sclk)));

    a_r8_done_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.cs_n);

endmodule

// File: rtl/stack_ack_sequencer.sv
module stack_ack_sequencer
    import ackseq_pkg::*;
#(
    parameter int          N_DEV        = 8,      // 1..8 devices in the chain
    parameter int          DIV_W        = 8,
    parameter logic [5:0]  RDSEL_ADDR   = 6'h1C,  // readback selector register
    parameter logic [7:0]  RDSEL_VAL    = 8'h0E,  // must be nonzero for acks to pass down
    parameter logic [5:0]  CTRL_HI_ADDR = 6'h0D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       ctrl_hi,
    input  logic [DIV_W-1:0] sclk_div,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [N_DEV-1:0] ack_vec,
    output logic [N_DEV-1:0] crc_err_vec
);

    localparam int LAST  = N_DEV + 1;
    localparam int IDX_W = $clog2(N_DEV + 2);

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [DIV_W-1:0] div;
        logic [7:0]       ctrl;
        logic [N_DEV-1:0] ack;
        logic [N_DEV-1:0] err;
        logic             go;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic               eng_idle, eng_fdone, eng_ok;
    logic [FRAME_W-1:0] eng_rx;
    logic [HDR_W-1:0]   hdr;

    // R3/R4: header of the frame at the current index
    always_comb begin
        if (q.idx == IDX_W'(0))
            hdr = make_hdr(BCAST_DEV, RDSEL_ADDR, RDSEL_VAL, 1'b1);
        else if (q.idx == IDX_W'(1))
            hdr = make_hdr(BCAST_DEV, CTRL_HI_ADDR, q.ctrl, 1'b1);
        else
            hdr = make_hdr(POLL_DEV, 6'h00, 8'h00, 1'b0);
    end

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_RUN;
                    d.div  = sclk_div;   // R6: latched once
                    d.ctrl = ctrl_hi;
                    d.ack  = '0;         // R9
                    d.err  = '0;
                    d.idx  = '0;
                    d.go   = 1'b1;
                end
            end
            S_RUN: begin                 // R10: start not looked at here
                if (eng_fdone) begin
                    for (int i = 0; i < N_DEV; i++) begin
                        if (q.idx == IDX_W'(i + 2)) begin
                            d.ack[i] = eng_rx[ACK_POS] & eng_ok;   // R7
                            d.err[i] = !eng_ok;                    // R8
                        end
                    end
                    if (q.idx == IDX_W'(LAST)) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.go  = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: '0, div: '0, ctrl: '0, ack: '0, err: '0,
                   go: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    ackseq_spi_engine #(.DIV_W(DIV_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (q.go),
        .hdr        (hdr),
        .half_div   (q.div),
        .miso       (miso),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .idle       (eng_idle),
        .frame_done (eng_fdone),
        .rx_word    (eng_rx),
        .rx_crc_ok  (eng_ok)
    );

    assign busy        = (q.st == S_RUN);
    assign done        = q.done;
    assign ack_vec     = q.ack;
    assign crc_err_vec = q.err;

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    a_r8_ack_err_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ((q.ack & q.err) == '0));

    a_r10_cfg_frozen_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RUN && $past(q.st) == S_RUN) |-> ($stable(q.div) && $stable(q.ctrl)));

    a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_W'(LAST));

    a_r9_launch_into_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
        q.go |-> eng_idle);

    a_r9_results_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == S_IDLE && !$past(start)) |-> ($stable(q.ack) && $stable(q.err)));

endmodule

// File: tb/stack_ack_sequencer_tb.sv
module stack_ack_sequencer_tb;

    localparam int N     = 8;
    localparam int DIV_W = 8;
    localparam logic [31:0] POLL_WORD = 32'hF800030A;

    // vector: {ctrl, div, ack mask, corrupted-CRC mask}
    localparam int NVEC = 5;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h5A, 8'd0, 8'hFF, 8'h00},
        {8'hA5, 8'd1, 8'h00, 8'h00},
        {8'h3C, 8'd2, 8'hB6, 8'h00},
        {8'hC3, 8'd1, 8'hFF, 8'h81},
        {8'h01, 8'd0, 8'h0F, 8'h30}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       ctrl_hi = 8'h00;
    logic [DIV_W-1:0] sclk_div = '0;
    logic             miso = 1'b0;
    logic             sclk, cs_n, mosi, busy, done;
    logic [N-1:0]     ack_vec, crc_err_vec;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stack_ack_sequencer #(.N_DEV(N), .DIV_W(DIV_W)) u_dut (
        .clk, .rst_n, .start, .ctrl_hi, .sclk_div, .miso,
        .sclk, .cs_n, .mosi, .busy, .done, .ack_vec, .crc_err_vec
    );

    // remainder of the n-bit value v divided by x^8+x^5+x^3+x^2+x+1
    function automatic logic [7:0] ref_crc(input logic [31:0] v, input int n);
        logic [39:0] r;
        r = {8'h00, v};
        for (int i = n - 1; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h12F;
        return r[7:0];
    endfunction

    function automatic logic [31:0] ref_cmd(input logic [4:0] dev, input logic [5:0] ra,
                                            input logic [7:0] dat, input logic all);
        logic [20:0] h;
        h = {dev, ra, dat, all, 1'b0};
        return {h, ref_crc({11'd0, h}, 21), 3'b010};
    endfunction

    // ---- stack model ----
    logic [7:0]  cur_ctrl, cur_ack, cur_bad;
    int          cur_div;
    logic [31:0] resp, mcap;
    logic [31:0] cap [16];
    int rbit, redge, fidx, edge_bad, per_bad, cyc, last_rise;

    always @(posedge clk) cyc++;

    function automatic logic [31:0] make_resp(input int k);
        logic [21:0] h;
        logic [7:0]  c;
        h = {5'(k), 6'h0D, cur_ctrl, 2'b00, cur_ack[k]};
        c = ref_crc({10'd0, h}, 22);
        if (cur_bad[k]) c = c ^ 8'h01;
        return {h, c, 2'b00};
    endfunction

    always @(negedge cs_n) begin
        if (fidx >= 2 && fidx < N + 2) resp = make_resp(fidx - 2);
        else                           resp = 32'h0;
        rbit  = 31;
        miso  = resp[31];
        redge = 0;
        mcap  = 32'h0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            mcap = {mcap[30:0], mosi};
            if (redge > 0 && (cyc - last_rise) != 2 * (cur_div + 1)) per_bad++;
            last_rise = cyc;
            redge++;
            if (rbit > 0) begin
                rbit--;
                miso = resp[rbit];
            end
        end
    end

    always @(posedge cs_n) begin
        if (fidx < 16) cap[fidx] = mcap;
        if (redge != 32) edge_bad++;
        fidx++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic [7:0] c, input logic [7:0] dv,
                           input logic [7:0] a, input logic [7:0] b, input bit disturb);
        int bad_poll;
        cur_ctrl = c; cur_div = int'(dv); cur_ack = a; cur_bad = b;
        fidx = 0; edge_bad = 0; per_bad = 0;
        @(negedge clk);
        ctrl_hi = c; sclk_div = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", 32'(busy), 32'h1);
        chk(ack_vec == '0 && crc_err_vec == '0, "R9 vectors cleared at start",
            {ack_vec, crc_err_vec}, 32'h0);
        if (disturb) begin
            repeat (300) @(negedge clk);
            start = 1'b1; ctrl_hi = ~c; sclk_div = dv + 8'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(cap[0] == ref_cmd(5'h00, 6'h1C, 8'h0E, 1'b1), "R2 R3 frame 0 word", cap[0],
            ref_cmd(5'h00, 6'h1C, 8'h0E, 1'b1));
        chk(cap[1] == ref_cmd(5'h00, 6'h0D, c, 1'b1), "R2 R3 frame 1 word", cap[1],
            ref_cmd(5'h00, 6'h0D, c, 1'b1));
        bad_poll = 0;
        for (int k = 2; k < N + 2; k++) if (cap[k] != POLL_WORD) bad_poll++;
        chk(bad_poll == 0, "R4 readback words", 32'(bad_poll), 32'h0);
        chk(fidx == N + 2, "R4 frame count", 32'(fidx), 32'(N + 2));
        chk(edge_bad == 0, "R5 rising edges per frame", 32'(edge_bad), 32'h0);
        chk(per_bad == 0, "R6 sclk period", 32'(per_bad), 32'h0);
        chk(ack_vec == (a & ~b), "R7 R8 ack_vec", 32'(ack_vec), 32'(a & ~b));
        chk(crc_err_vec == b, "R8 crc_err_vec", 32'(crc_err_vec), 32'(b));
        chk(busy == 1'b0, "R9 busy low at done", 32'(busy), 32'h0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'h0);
        ctrl_hi = 8'h00; sclk_div = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 lines in reset", {30'd0, cs_n, sclk}, 32'h3);
        chk(busy == 1'b0 && done == 1'b0, "R1 status in reset", {30'd0, busy, done}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1 && !busy && !done, "R1 idle after reset",
            {28'd0, cs_n, sclk, busy, done}, 32'hC);
        chk(ack_vec == '0 && crc_err_vec == '0, "R1 vectors after reset",
            {ack_vec, crc_err_vec}, 32'h0);

        for (int v = 0; v < NVEC; v++)
            run_seq(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);

        // R10/R6: second start mid-run with new byte and divider is ignored
        run_seq(8'h96, 8'd1, 8'h5D, 8'h02, 1'b1);

        // R9: results hold while idle
        repeat (20) @(negedge clk);
        chk(ack_vec == 8'h5D && crc_err_vec == 8'h02, "R9 vectors hold while idle",
            {ack_vec, crc_err_vec}, {8'h5D, 8'h02});
        chk(cs_n == 1'b1 && sclk == 1'b1, "R5 lines idle between runs",
            {30'd0, cs_n, sclk}, 32'h3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual no done, expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule